// File: doc/BRIEF.md
# Eight-Channel Output-Control Serial Slave

This block is the serial front end of an eight-channel output driver. A host talks to it in clock mode 0: data goes in on the serial input, is sampled on rising serial-clock edges, and travels most significant bit first. When the select line rises, the block takes the last received frame and writes its channel bits into the output register. A static width input picks a short frame of one bit per channel, or a long frame. The long frame adds a status nibble and a four-bit check code, and the check code is verified before the command is accepted.

While the command shifts in, the block shifts out a fault frame. The fault frame is captured when select falls. It holds sticky per-channel overtemperature flags, and in the long format it also holds four status bits and its own check code. Bits clocked beyond the frame length come back out on the serial output after the fault bits, so several devices can share one chain. The serial pins are synchronised into a faster system clock, and all edges are detected in that clock domain.

Top module: `spi_chan_ctl_slave`

## Requirements
- R1: `sdo_oe_o` is low while select is idle (high). After select falls, `sdo_o` shows the MSB of the fault frame. `sdo_o` changes only after a falling serial-clock edge or a select falling edge.
- R2: At the select rising edge of an accepted frame, `chan_on_o[i]` takes command bit for channel i, where 1 means on. In the short frame the command is the last 8 bits received, with channel 7 first. In the long frame the channels are the first 8 of the last 16 bits received.
- R3: The short fault frame is the 8 latched overtemperature flags, with channel 7 sent first.
- R4: The long fault frame, in send order, is: flags 7..0, feedback-ok, case-warning, previous-frame-error, supply-good, then C2, C1, C0, and NOT C0. C0 is the XOR of the 8 flags. C1 is the XOR of the odd-index flags, the error bit and feedback-ok. C2 is the XOR of the even-index flags, supply-good and case-warning.
- R5: The long command is channels 7..0, then four ignored bits, then C2, C1, C0 and NOT C0. C0 is the XOR of all channel bits, C1 is the XOR of the odd channels, and C2 is the XOR of the even channels. If the code mismatches, the block sets `frame_err_o` and leaves `chan_on_o` unchanged.
- R6: A transfer is rejected in either mode if its count of rising serial-clock edges is not a multiple of 8 or is below the frame length. A rejected transfer sets `frame_err_o` and leaves `chan_on_o` unchanged.
- R7: After each transfer, `frame_err_o` is high exactly when that transfer was rejected. Its value is sent as the error bit of the next long fault frame.
- R8: A channel overtemperature pulse of one cycle is held until the next select rising edge, and it appears in the next fault frame. At that edge the flags are reloaded from the live inputs.
- R9: Bits received beyond the frame length leave on `sdo_o` right after the fault bits, in the order received.
- R10: Serial-clock edges while select is idle have no effect on the outputs or on the next transfer's length count.
- R11: After reset, `chan_on_o` is all zero, `frame_err_o` is low and `sdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, mode 0 |
| ss_n_i | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, forced low when not enabled |
| sdo_oe_o | output | 1 | Enable for the serial output pad driver |
| wide_i | input | 1 | Frame width: 0 short, 1 long; change only while select is idle |
| ovt_i | input | CH | Live per-channel overtemperature |
| fb_ok_i | input | 1 | Regulator feedback-ok status |
| twarn_i | input | 1 | Case temperature warning status |
| pgood_i | input | 1 | Supply-good status |
| chan_on_o | output | CH | Channel enable register |
| frame_err_o | output | 1 | Last transfer rejected (check code or length) |

## Verification
Some rules are checked by assertions on every cycle. The output enable must follow the idle select line. The serial output may change only on a falling clock or select edge. Idle clock activity must leave the channel register alone. A rejected frame must hold the register, and an accepted frame must load it. A misaligned count must raise the error. Flags must stay sticky between clears. The bench scenarios cover what those per-cycle rules cannot show: the bit-exact layout and check codes of both fault frames, forwarding of surplus bits in a daisy chain, and the error bit's carry into the following frame.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

   typedef enum logic {FRM_SHORT = 1'b0, FRM_LONG = 1'b1} frm_mode_e;

   // order matters: packed into the long fault frame MSB first
   typedef struct packed {
      logic fb_ok;
      logic twarn;
      logic pc;
      logic pg;
   } stat_t;

   localparam int MAX_W = 32;

   // XOR of v[first], v[first+step], ... below index n
   function automatic logic xor_sel(input logic [MAX_W-1:0] v, input int n,
                                    input int step, input int first);
      logic r;
      r = 1'b0;
      for (int i = first; i < n; i += step) r ^= v[i];
      return r;
   endfunction

   // four-bit code {C2, C1, C0, ~C0}; extra terms fold into C1 and C2
   function automatic logic [3:0] par_code(input logic [MAX_W-1:0] v, input int n,
                                           input logic odd_x, input logic even_x);
      logic c0, c1, c2;
      c0 = xor_sel(v, n, 1, 0);
      c1 = odd_x ^ xor_sel(v, n, 2, 1);
      c2 = even_x ^ xor_sel(v, n, 2, 0);
      return {c2, c1, c0, ~c0};
   endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int N = 3,
   parameter int STAGES = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   logic [N-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stg
         logic [N-1:0] q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= din_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= g_stg[s-1].q;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= g_stg[STAGES-1].q;
   end

   assign lvl_o  = g_stg[STAGES-1].q;
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/spi_fault_latch.sv
module spi_fault_latch #(
   parameter int CH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] ovt_i,
   input  logic          clear_i,
   output logic [CH-1:0] flags_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_o <= '0;
      else if (clear_i) flags_o <= ovt_i;
      else              flags_o <= flags_o | ovt_i;
   end

   // R8: any flag seen in a cycle without a clear is held afterwards
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((flags_o & $past(ovt_i)) == $past(ovt_i)));

endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
   import spi_ctl_pkg::*;
#(
   parameter int CH = 8,
   parameter int GRAN = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  frm_mode_e                     mode_i,
   input  logic                          sel_act_i,
   input  logic                          sel_fall_i,
   input  logic                          sel_rise_i,
   input  logic                          sclk_rise_i,
   input  logic                          sclk_fall_i,
   input  logic                          sdi_i,
   input  logic [CH+7:0]                 frame_i,
   output logic [CH+7:0]                 shreg_o,
   output logic [$clog2(CH+9)-1:0]       sat_cnt_o,
   output logic [$clog2(GRAN)-1:0]       mod_cnt_o,
   output logic                          sdo_o,
   output logic                          oe_o
);

   localparam int LONG = CH + 8;
   localparam int CWS  = $clog2(LONG + 1);
   localparam int CWM  = $clog2(GRAN);

   logic top_bit, load_top;

   always_comb begin
      top_bit  = (mode_i == FRM_LONG) ? shreg_o[LONG-1] : shreg_o[CH-1];
      load_top = (mode_i == FRM_LONG) ? frame_i[LONG-1] : frame_i[CH-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_o   <= '0;
         sat_cnt_o <= '0;
         mod_cnt_o <= '0;
         sdo_o     <= 1'b0;
         oe_o      <= 1'b0;
      end else begin
         if (sel_fall_i) begin
            shreg_o   <= frame_i;
            sdo_o     <= load_top;
            oe_o      <= 1'b1;
            sat_cnt_o <= '0;
            mod_cnt_o <= '0;
         end else if (sel_act_i) begin
            if (sclk_rise_i) begin
               shreg_o   <= {shreg_o[LONG-2:0], sdi_i};
               mod_cnt_o <= mod_cnt_o + CWM'(1);
               if (sat_cnt_o != CWS'(LONG)) sat_cnt_o <= sat_cnt_o + CWS'(1);
            end
            if (sclk_fall_i) sdo_o <= top_bit;
         end
         if (sel_rise_i) oe_o <= 1'b0;
      end
   end

   // R1: serial output moves only after a falling clock or select edge
   p_sdo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall_i && !sel_fall_i) |=> $stable(sdo_o));

endmodule

// File: rtl/spi_cmd_eval.sv
module spi_cmd_eval
   import spi_ctl_pkg::*;
#(
   parameter int CH = 8,
   parameter int GRAN = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  frm_mode_e                 mode_i,
   input  logic                      sel_rise_i,
   input  logic [CH+7:0]             shreg_i,
   input  logic [$clog2(CH+9)-1:0]   sat_cnt_i,
   input  logic [$clog2(GRAN)-1:0]   mod_cnt_i,
   output logic [CH-1:0]             chan_on_o,
   output logic                      frame_err_o
);

   localparam int LONG = CH + 8;
   localparam int CWS  = $clog2(LONG + 1);

   logic [CH-1:0] cmd_short, cmd_long, cmd;
   logic          len_ok, code_ok, accept;
   logic          unused_dc;

   assign unused_dc = ^shreg_i[LONG-CH-1:4];

   always_comb begin
      cmd_short = shreg_i[CH-1:0];
      cmd_long  = shreg_i[LONG-1 -: CH];
      len_ok    = (mod_cnt_i == '0) &&
                  (sat_cnt_i >= ((mode_i == FRM_LONG) ? CWS'(LONG) : CWS'(CH)));
      code_ok   = (shreg_i[3:0] == par_code(MAX_W'(cmd_long), CH, 1'b0, 1'b0));
      accept    = len_ok && ((mode_i == FRM_SHORT) || code_ok);
      cmd       = (mode_i == FRM_LONG) ? cmd_long : cmd_short;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_on_o   <= '0;
         frame_err_o <= 1'b0;
      end else if (sel_rise_i) begin
         if (accept) chan_on_o <= cmd;
         frame_err_o <= !accept;
      end
   end

   // R5: a rejected frame leaves the channel register alone
   p_hold_on_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise_i && !accept) |=> $stable(chan_on_o));

   // R2: an accepted frame loads the command it carried
   p_load_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise_i && accept) |=> (chan_on_o == $past(cmd)));

   // R6: a misaligned edge count always raises the error flag
   p_misaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise_i && (mod_cnt_i != '0)) |=> frame_err_o);

endmodule

// File: rtl/spi_chan_ctl_slave.sv
module spi_chan_ctl_slave
   import spi_ctl_pkg::*;
#(
   parameter int CH = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GRAN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_i,
   input  logic          ss_n_i,
   input  logic          sdi_i,
   output logic          sdo_o,
   output logic          sdo_oe_o,
   input  logic          wide_i,
   input  logic [CH-1:0] ovt_i,
   input  logic          fb_ok_i,
   input  logic          twarn_i,
   input  logic          pgood_i,
   output logic [CH-1:0] chan_on_o,
   output logic          frame_err_o
);

   localparam int LONG = CH + 8;
   localparam int CWS  = $clog2(LONG + 1);
   localparam int CWM  = $clog2(GRAN);

   initial begin
      assert (CH >= 2 && (CH % 2) == 0 && LONG <= MAX_W)
         else $error("CH must be even, at least 2, and fit the parity helper");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (GRAN >= 2 && (GRAN & (GRAN - 1)) == 0 && (CH % GRAN) == 0)
         else $error("GRAN must be a power of two dividing CH");
   end

   frm_mode_e            mode;
   logic [2:0]           s_lvl, s_rise, s_fall;
   logic                 ss_idle, sel_fall, sel_rise, sclk_rise, sclk_fall, sdi_s;
   logic                 unused_edges;
   logic [CH-1:0]        flags;
   stat_t                st;
   logic [LONG-1:0]      frame_long, frame_short, frame_src, shreg;
   logic [CWS-1:0]       sat_cnt;
   logic [CWM-1:0]       mod_cnt;
   logic                 sdo_q, oe_q;

   assign mode = frm_mode_e'(wide_i);

   spi_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  ({ss_n_i, sclk_i, sdi_i}),
      .lvl_o  (s_lvl),
      .rise_o (s_rise),
      .fall_o (s_fall)
   );

   assign ss_idle      = s_lvl[2];
   assign sel_fall     = s_fall[2];
   assign sel_rise     = s_rise[2];
   assign sclk_rise    = s_rise[1];
   assign sclk_fall    = s_fall[1];
   assign sdi_s        = s_lvl[0];
   assign unused_edges = s_lvl[1] ^ s_rise[0] ^ s_fall[0];

   spi_fault_latch #(.CH(CH)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovt_i   (ovt_i),
      .clear_i (sel_rise),
      .flags_o (flags)
   );

   always_comb begin
      st.fb_ok    = fb_ok_i;
      st.twarn    = twarn_i;
      st.pc       = frame_err_o;
      st.pg       = pgood_i;
      frame_long  = {flags, st, par_code(MAX_W'(flags), CH, st.pc ^ st.fb_ok, st.pg ^ st.twarn)};
      frame_short = LONG'(flags);
      frame_src   = (mode == FRM_LONG) ? frame_long : frame_short;
   end

   spi_frame_shift #(.CH(CH), .GRAN(GRAN)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .sel_act_i   (!ss_idle),
      .sel_fall_i  (sel_fall),
      .sel_rise_i  (sel_rise),
      .sclk_rise_i (sclk_rise),
      .sclk_fall_i (sclk_fall),
      .sdi_i       (sdi_s),
      .frame_i     (frame_src),
      .shreg_o     (shreg),
      .sat_cnt_o   (sat_cnt),
      .mod_cnt_o   (mod_cnt),
      .sdo_o       (sdo_q),
      .oe_o        (oe_q)
   );

   spi_cmd_eval #(.CH(CH), .GRAN(GRAN)) u_eval (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .sel_rise_i  (sel_rise),
      .shreg_i     (shreg),
      .sat_cnt_i   (sat_cnt),
      .mod_cnt_i   (mod_cnt),
      .chan_on_o   (chan_on_o),
      .frame_err_o (frame_err_o)
   );

   assign sdo_oe_o = oe_q;
   assign sdo_o    = sdo_q & oe_q;

   // R1: output driver is released whenever select is idle
   p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ss_idle |=> !sdo_oe_o);

   // R10: clock activity with select idle never touches the channels
   p_idle_sclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_idle && !sel_rise) |=> $stable(chan_on_o));

endmodule

// File: tb/spi_chan_ctl_slave_test.sv
module spi_chan_ctl_slave_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, ss_n = 1'b1, sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic       wide = 1'b0;
   logic [7:0] ovt = 8'h00;
   logic       fb_ok = 1'b0, twarn = 1'b0, pgood = 1'b0;
   logic [7:0] chan_on;
   logic       frame_err;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic  exp_q[$];
   string tag_q[$];

   logic [7:0] m_chan = 8'h00, m_flags = 8'h00;
   logic       m_err = 1'b0;

   always #4 clk = ~clk;

   spi_chan_ctl_slave uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ss_n_i(ss_n), .sdi_i(sdi),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wide_i(wide), .ovt_i(ovt),
      .fb_ok_i(fb_ok), .twarn_i(twarn), .pgood_i(pgood),
      .chan_on_o(chan_on), .frame_err_o(frame_err)
   );

   function automatic logic [3:0] code4(input logic [7:0] v, input logic xo, input logic xe);
      logic c0, c1, c2;
      c0 = ^v;
      c1 = xo ^ v[1] ^ v[3] ^ v[5] ^ v[7];
      c2 = xe ^ v[0] ^ v[2] ^ v[4] ^ v[6];
      return {c2, c1, c0, ~c0};
   endfunction

   function automatic logic [15:0] good_cmd(input logic [7:0] ch);
      return {ch, 4'b0000, code4(ch, 1'b0, 1'b0)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected serial bit per rising serial clock
   always @(posedge sclk) begin
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (sdo !== e) begin
            n_fail++;
            $display("FAIL %s serial bit actual=%b expected=%b", t, sdo, e);
         end
      end
   end

   task automatic pulse_ovt(input logic [7:0] v);
      @(negedge clk) ovt = v;
      @(negedge clk) ovt = 8'h00;
      m_flags |= v;
      repeat (4) @(negedge clk);
   endtask

   // driver: pushes expected serial bits, runs the transfer, updates the model
   task automatic xfer(input int n, input logic [31:0] tx, input string tag);
      int          flen;
      logic [15:0] fr;
      logic        len_ok, ok;
      logic [7:0]  cmd;
      flen = wide ? 16 : 8;
      fr   = wide ? {m_flags, fb_ok, twarn, m_err, pgood,
                     code4(m_flags, m_err ^ fb_ok, pgood ^ twarn)}
                  : {8'h00, m_flags};
      for (int k = 0; k < n; k++) begin
         if (k < flen) exp_q.push_back(fr[flen-1-k]);
         else          exp_q.push_back(tx[n-1-(k-flen)]);
         tag_q.push_back(tag);
      end
      @(negedge clk) ss_n = 1'b0;
      repeat (8) @(negedge clk);
      check("R1 output enabled while selected", 32'(sdo_oe), 32'd1);
      for (int k = 0; k < n; k++) begin
         sdi = tx[n-1-k];
         repeat (8) @(negedge clk);
         sclk = 1'b1;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (8) @(negedge clk);
      ss_n = 1'b1;
      repeat (10) @(negedge clk);
      len_ok = ((n % 8) == 0) && (n >= flen);
      cmd    = wide ? tx[15:8] : tx[7:0];
      ok     = len_ok && (!wide || (tx[3:0] == code4(tx[15:8], 1'b0, 1'b0)));
      if (ok) m_chan = cmd;
      m_err   = !ok;
      m_flags = ovt;
      check("R2 channel register", 32'(chan_on), 32'(m_chan));
      check("R7 frame error flag", 32'(frame_err), 32'(m_err));
      check("R1 output released after select rise", 32'(sdo_oe), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R11 reset state
      check("R11 channels after reset", 32'(chan_on), 32'h0);
      check("R11 error after reset", 32'(frame_err), 32'h0);
      check("R11 enable after reset", 32'(sdo_oe), 32'h0);

      // R10 idle clocks: no effect, and next 8-bit frame still counts 8
      for (int i = 0; i < 5; i++) begin
         repeat (8) @(negedge clk) sclk = 1'b1;
         repeat (8) @(negedge clk) sclk = 1'b0;
      end
      check("R10 enable stays low with idle clocking", 32'(sdo_oe), 32'h0);
      check("R10 channels untouched by idle clocking", 32'(chan_on), 32'h0);

      // R3 short fault frame with latched flags
      pulse_ovt(8'h12);
      xfer(8, 32'hA5, "R3");
      check("R10 idle clocks not counted", 32'(frame_err), 32'h0);

      // R8 flags cleared by previous transfer, then a fresh pulse held
      xfer(8, 32'h0F, "R8");
      pulse_ovt(8'h81);
      xfer(8, 32'h3C, "R8");

      // R6 short frame with 4 bits rejected
      xfer(4, 32'h9, "R6");
      check("R6 channels held after short count", 32'(chan_on), 32'h3C);

      // R9 daisy chain in short mode: 16 bits, first byte forwarded
      xfer(16, 32'hE724, "R9");

      // long mode
      wide = 1'b1; fb_ok = 1'b1; pgood = 1'b1; twarn = 1'b0;
      repeat (4) @(negedge clk);
      pulse_ovt(8'h40);
      xfer(16, 32'(good_cmd(8'h3C)), "R4");

      // R5 corrupted check code rejected
      xfer(16, 32'(good_cmd(8'h5A) ^ 16'h0002), "R4");
      check("R5 channels held on bad code", 32'(chan_on), 32'h3C);
      check("R5 error raised on bad code", 32'(frame_err), 32'h1);

      // R7 error bit travels in next fault frame, then clears
      twarn = 1'b1;
      xfer(16, 32'(good_cmd(8'hC3)), "R7");
      check("R7 error cleared by good frame", 32'(frame_err), 32'h0);

      // R6 twelve bits in long mode
      xfer(12, 32'h0ABC, "R6");
      check("R6 channels held after 12 bits", 32'(chan_on), 32'hC3);

      // R9 daisy chain in long mode: 24 bits, first byte forwarded
      pulse_ovt(8'h05);
      xfer(24, {8'h00, 8'h5A, good_cmd(8'h99)}, "R9");
      check("R9 trailing command applied", 32'(chan_on), 32'h99);

      // R5 ignored bits do not affect acceptance
      xfer(16, 32'(good_cmd(8'h66) | 16'h00F0), "R5");
      check("R5 ignored nibble accepted", 32'(chan_on), 32'h66);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule